// File: doc/BRIEF.md
# Code-Density Calibration Table Builder for a Fine-Time Interpolator

This block turns raw fine-time codes from a delay-line interpolator into calibrated picosecond times. A start pulse clears a per-code hit histogram. The block then counts incoming raw codes until a programmed total of 2^m hits has arrived. The hits are assumed to be uncorrelated with the clock, so each code's share of the total gives the real width of that bin within one clock period T0.

After collection, the block walks the 64 bins once, one bin per cycle. For each bin it stores the bin's midpoint time: the sum of the widths of all lower bins plus half the width of the bin itself. It evaluates this exactly as floor((2·Σ_{j<k} n_j + n_k)·T0 / 2^(m+1)), so the result is rounded toward zero. Once the table is ready, raw codes are translated through it with one cycle of latency. The table is rebuilt with a fresh start whenever operating conditions drift.

Top module: `tdc_bin_calibrator`

## Requirements
- R1: After reset, busy, ready and lookup_valid are 0 and lookup_time is 0.
- R2: A start pulse while the block is idle or ready raises busy on the next cycle and clears ready. A start pulse while busy has no effect.
- R3: After start, the block spends exactly 64 cycles clearing the histogram. Hits offered while clearing, idle, building or ready are not counted.
- R4: Collection ends in the cycle that accepts the 2^m-th valid hit. Here m is log2_hits sampled at start, and values above 19 are treated as 19.
- R5: Building takes exactly 64 cycles after collection ends. Ready then goes high and busy goes low, and ready stays high until the next start.
- R6: The table entry for code 0 equals floor(n0·T0 / 2^(m+1)), where n0 is the hit count of code 0 and T0 is period_ps sampled at start.
- R7: The table entry for code k equals floor((2·(n0+…+n(k−1)) + nk)·T0 / 2^(m+1)).
- R8: A lookup request in a cycle where ready is high gives lookup_valid=1 on the next cycle, with lookup_time set to the table entry for lookup_code. In any other cycle the next lookup_valid is 0 and lookup_time is 0.
- R9: A rebuild uses only the hits of its own collection. No count from an earlier run carries over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new calibration run |
| period_ps | input | 16 | Clock period T0 in picoseconds, sampled at start |
| log2_hits | input | 5 | Exponent m of the hit total, sampled at start |
| hit_valid | input | 1 | A raw code is present this cycle |
| hit_code | input | 6 | Raw fine code of the hit |
| lookup_en | input | 1 | Request translation of lookup_code |
| lookup_code | input | 6 | Raw code to translate |
| busy | output | 1 | Clearing, collecting or building |
| ready | output | 1 | Table is valid |
| lookup_valid | output | 1 | lookup_time holds a translated value |
| lookup_time | output | 16 | Calibrated time in picoseconds |

## Verification
A miscounted histogram bin appears at the ports only after the build, but the error then spreads. Every table entry at or above the bad code shifts, so the first full sweep of lookups exposes it. A wrong collection or phase length moves the fall of busy and the rise of ready by at least one cycle. A per-clock comparison against the behavioural model flags that shift in the same cycle. If a count leaks from one run into the next, the table entries of the second run are wrong, and the sweep that follows that run catches it.

// File: rtl/tdc_bin_calibrator.sv
module tdc_bin_calibrator #(
  parameter int NBINS  = 64,
  parameter int CNT_W  = 20,
  parameter int TIME_W = 16,
  parameter int LOG_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [TIME_W-1:0]        period_ps,
  input  logic [LOG_W-1:0]         log2_hits,
  input  logic                     hit_valid,
  input  logic [$clog2(NBINS)-1:0] hit_code,
  input  logic                     lookup_en,
  input  logic [$clog2(NBINS)-1:0] lookup_code,
  output logic                     busy,
  output logic                     ready,
  output logic                     lookup_valid,
  output logic [TIME_W-1:0]        lookup_time
);
  localparam int CODE_W  = $clog2(NBINS);
  localparam int MAX_LOG = CNT_W - 1;
  localparam int SUM_W   = CNT_W + 2;
  localparam int PROD_W  = SUM_W + TIME_W;

  typedef enum logic [2:0] {S_IDLE, S_CLEAR, S_COLLECT, S_BUILD, S_READY} state_t;

  state_t              state;
  logic [CODE_W-1:0]   idx;
  logic [CNT_W:0]      hits, acc;
  logic [TIME_W-1:0]   t0_q;
  logic [LOG_W-1:0]    lg_q;
  logic [CNT_W-1:0]    hist [NBINS];
  logic [TIME_W-1:0]   lut  [NBINS];

  wire               last_idx = (idx == CODE_W'(NBINS - 1));
  wire [LOG_W-1:0]   lg_in    = (log2_hits > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : log2_hits;
  wire [CNT_W:0]     goal     = (CNT_W+1)'(1) << lg_q;
  wire               take     = (state == S_COLLECT) && hit_valid;
  wire               can_go   = start && (state == S_IDLE || state == S_READY);
  wire [SUM_W-1:0]   sum2     = {acc, 1'b0} + SUM_W'(hist[idx]);
  wire [PROD_W-1:0]  prod     = PROD_W'(sum2) * PROD_W'(t0_q);
  wire [TIME_W-1:0]  mid      = TIME_W'(prod >> (lg_q + LOG_W'(1)));

  assign busy  = (state == S_CLEAR) || (state == S_COLLECT) || (state == S_BUILD);
  assign ready = (state == S_READY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      hits  <= '0;
      acc   <= '0;
      t0_q  <= '0;
      lg_q  <= '0;
    end else begin
      case (state)
        S_IDLE, S_READY:
          if (can_go) begin
            state <= S_CLEAR;
            idx   <= '0;
            t0_q  <= period_ps;
            lg_q  <= lg_in;
          end
        S_CLEAR: begin
          idx <= idx + 1'b1;
          if (last_idx) begin
            state <= S_COLLECT;
            hits  <= '0;
          end
        end
        S_COLLECT:
          if (take) begin
            hits <= hits + 1'b1;
            if (hits + 1'b1 == goal) begin
              state <= S_BUILD;
              idx   <= '0;
              acc   <= '0;
            end
          end
        S_BUILD: begin
          idx <= idx + 1'b1;
          acc <= acc + (CNT_W+1)'(hist[idx]);
          if (last_idx) state <= S_READY;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_CLEAR)
      hist[idx] <= '0;
    else if (take)
      hist[hit_code] <= hist[hit_code] + 1'b1;
    if (state == S_BUILD)
      lut[idx] <= mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lookup_valid <= 1'b0;
      lookup_time  <= '0;
    end else begin
      lookup_valid <= ready && lookup_en;
      lookup_time  <= (ready && lookup_en) ? lut[lookup_code] : '0;
    end
  end
endmodule

module tdc_bin_calibrator_chk #(
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              ready,
  input logic              lookup_valid,
  input logic [TIME_W-1:0] lookup_time,
  input logic [TIME_W-1:0] t0_q
);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n) !(busy && ready));
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !ready));
  p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);
  p_valid_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |-> $past(ready));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |-> (lookup_time == '0));
  p_time_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && ready) |-> (lookup_time <= t0_q));
endmodule

bind tdc_bin_calibrator tdc_bin_calibrator_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ready(ready),
  .lookup_valid(lookup_valid), .lookup_time(lookup_time), .t0_q(t0_q)
);

// File: tb/test_tdc_bin_calibrator.sv
module test_tdc_bin_calibrator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] period_ps = '0;
  logic [4:0]  log2_hits = '0;
  logic        hit_valid = 1'b0;
  logic [5:0]  hit_code = '0;
  logic        lookup_en = 1'b0;
  logic [5:0]  lookup_code = '0;
  logic        busy, ready, lookup_valid;
  logic [15:0] lookup_time;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tdc_bin_calibrator i_tdc_bin_calibrator (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
    .log2_hits(log2_hits), .hit_valid(hit_valid), .hit_code(hit_code),
    .lookup_en(lookup_en), .lookup_code(lookup_code), .busy(busy),
    .ready(ready), .lookup_valid(lookup_valid), .lookup_time(lookup_time)
  );

  // behavioural reference: 0 idle, 1 clear, 2 collect, 3 build, 4 ready
  int      mst, mcnt, mlg;
  longint  mhits, mt0;
  longint  mhist [64];
  int      mtab  [64];
  bit      ev;
  int      et;

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; ev = 0; et = 0;
    end else begin
      ev = (mst == 4) && lookup_en;
      et = ev ? mtab[lookup_code] : 0;
      case (mst)
        0, 4: if (start) begin
          mst = 1; mcnt = 0; mt0 = period_ps;
          mlg = (log2_hits > 19) ? 19 : int'(log2_hits);
          foreach (mhist[i]) mhist[i] = 0;
        end
        1: begin mcnt++; if (mcnt == 64) begin mst = 2; mhits = 0; end end
        2: if (hit_valid) begin
          mhist[hit_code]++; mhits++;
          if (mhits == (longint'(1) << mlg)) begin
            longint a;
            a = 0;
            for (int k = 0; k < 64; k++) begin
              mtab[k] = int'((((2 * a + mhist[k]) * mt0) >> (mlg + 1)) & 16'hffff);
              a += mhist[k];
            end
            mst = 3; mcnt = 0;
          end
        end
        3: begin mcnt++; if (mcnt == 64) mst = 4; end
        default: mst = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (busy !== (mst >= 1 && mst <= 3)) begin
        n_bad++; $display("FAIL R2/R3/R4/R5 busy act=%0b exp=%0b t=%0t", busy, (mst >= 1 && mst <= 3), $time);
      end
      n_cmp++;
      if (ready !== (mst == 4)) begin
        n_bad++; $display("FAIL R4/R5 ready act=%0b exp=%0b t=%0t", ready, (mst == 4), $time);
      end
      n_cmp++;
      if (lookup_valid !== ev) begin
        n_bad++; $display("FAIL R8 lookup_valid act=%0b exp=%0b t=%0t", lookup_valid, ev, $time);
      end
      n_cmp++;
      if (int'(lookup_time) != et) begin
        n_bad++; $display("FAIL R6/R7/R9 lookup_time act=%0d exp=%0d t=%0t", lookup_time, et, $time);
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++; $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic kick(input logic [15:0] t0, input logic [4:0] lg);
    @(negedge clk);
    start = 1'b1; period_ps = t0; log2_hits = lg;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 5000 && !ready; i++) @(negedge clk);
  endtask

  task automatic sweep();
    for (int c = 0; c < 64; c++) begin
      @(negedge clk); lookup_en = 1'b1; lookup_code = 6'(c);
    end
    @(negedge clk); lookup_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 0 && ready == 0, "R1 busy/ready", int'({busy, ready}), 0);
    check(lookup_valid == 0 && lookup_time == 0, "R1 lookup", int'(lookup_time), 0);
    rst_n = 1'b1;
    // R8 lookups while idle stay invalid
    lookup_en = 1'b1; lookup_code = 6'd3;
    repeat (3) @(negedge clk);
    check(lookup_valid == 0, "R8 idle lookup", int'(lookup_valid), 0);
    lookup_en = 1'b0;

    // run 1: m=4, T0=5000; hits during clear ignored (R3), restart ignored (R2)
    kick(16'd5000, 5'd4);
    check(busy == 1, "R2 busy after start", int'(busy), 1);
    hit_valid = 1'b1; hit_code = 6'd5;
    repeat (10) @(negedge clk);
    hit_valid = 1'b0;
    start = 1'b1; log2_hits = 5'd0; @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      hit_valid = 1'b1; hit_code = 6'((i * 7) % 64);
      @(negedge clk);
      hit_valid = 1'b0;
      if (i % 3 == 0) @(negedge clk);
    end
    // hits during build are not counted (R3); lookups during build invalid (R8)
    hit_valid = 1'b1; hit_code = 6'd0; lookup_en = 1'b1;
    repeat (8) @(negedge clk);
    hit_valid = 1'b0; lookup_en = 1'b0;
    wait_ready();
    check(ready == 1, "R5 ready after run 1", int'(ready), 1);
    sweep();

    // run 2: R9 rebuild from ready, m=6, T0=10000, skewed code density
    kick(16'd10000, 5'd6);
    repeat (64) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      hit_valid = 1'b1; hit_code = 6'((i * i) % 64);
      @(negedge clk);
    end
    hit_valid = 1'b0;
    wait_ready();
    sweep();

    // run 3: R4 single hit total (m=0), R6/R7 edge values
    kick(16'd4999, 5'd0);
    repeat (64) @(negedge clk);
    hit_valid = 1'b1; hit_code = 6'd63;
    @(negedge clk);
    hit_valid = 1'b0;
    check(busy == 1, "R4 build after one hit", int'(busy), 1);
    wait_ready();
    lookup_en = 1'b1; lookup_code = 6'd63;
    @(negedge clk);
    check(lookup_time == 16'd2499, "R7 code 63 single hit", int'(lookup_time), 2499);
    lookup_code = 6'd0;
    @(negedge clk);
    check(lookup_valid == 1 && lookup_time == 0, "R6 code 0 empty", int'(lookup_time), 0);
    lookup_en = 1'b0;
    @(negedge clk);
    sweep();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule